// File: doc/BRIEF.md
# PHY Management Serial Slave with Register File

This block is the station-management end of a 10/100 Ethernet transceiver. It runs on the management clock (MDC). It watches the bidirectional management data line for two-bit-opcode read and write frames. It answers only frames that carry the five-bit address strapped onto it at reset. Behind the serial engine sits a small file of sixteen-bit registers: control, status, two identifier words, advertisement, partner ability and expansion at addresses 0 to 6, and vendor registers at 17 to 20.

The control word has a soft-reset bit and a restart-negotiation bit, and both clear themselves. The status word has a link bit that latches low and jabber and remote-fault bits that latch high. Register 17 collects interrupt events, and reading it clears them. Register 18 masks them onto an active-low interrupt pin. The datapath functions that these bits steer are not part of the block. Their controls leave it as plain register ports, and their status enters as plain inputs.

A frame is preamble ones, then start `01`, opcode (`10` read, `01` write), PHY address, register address, two turnaround bits and sixteen data bits, each field sent MSB first. After reset the slave needs a full run of preamble. Later frames may omit the preamble when suppression is enabled, provided at least one idle one separates them.

Top module: `phy_mgmt_slave`

## Requirements
- R1: After reset, register 0 reads 3000h (speed and negotiation-enable set) for a nonzero strap, register 2 reads 1C04h, register 4 reads 01E1h, register 5 mirrors the partner-ability input, register 20 holds the strap in bits 7:3 and a 1 in bit 1, the interrupt pin is high and the data line is not driven.
- R2: The first frame after a hardware reset is answered only if at least 32 consecutive ones precede its start bits; a frame with 31 is ignored.
- R3: Once a frame has completed, a frame preceded by just one idle one is answered while register 20 bit 1 is 1 and ignored while it is 0; register 1 bit 6 reads back register 20 bit 1.
- R4: A frame whose PHY address differs from the strapped one gets no drive on the line, and its write data changes nothing.
- R5: In a read, the slave leaves the line released for the first turnaround bit, drives 0 for the second, then drives the 16 data bits MSB first, each updated after a rising MDC edge, and releases the line after the last one.
- R6: A strap of 00000 sets the isolate bit (register 0 bit 10) at reset; writing 00000 into the register 20 address field later does not set it.
- R7: Writing 1 to register 0 bit 15 returns every register to its default, including the strap-derived ones, and the bit reads back 0.
- R8: Register 0 bit 9 stays set after it is written to 1 until the negotiation-restart acknowledge input is seen, and then clears.
- R9: Register 1 bit 2 (link) latches a low link input, bits 1 (jabber) and 4 (remote fault) latch a high pulse on their inputs, and a read of register 1 reloads them from the live inputs.
- R10: The interrupt pin is low while any bit of register 17 (set by a pulse on the matching event input) is enabled by the same bit of register 18; a read of register 17 clears it.
- R11: Addresses outside 0 to 6 and 17 to 20 read 0000h and ignore writes; the identifier registers ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mdc | input | 1 | Management clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| mdio_in | input | 1 | Sampled level of the management data line |
| mdio_out | output | 1 | Level the slave drives on the data line |
| mdio_oe | output | 1 | Drive enable for the data line |
| strap_addr | input | 5 | PHY address straps, sampled at reset |
| link_up | input | 1 | Live link-good indication |
| jabber_evt | input | 1 | Jabber detection pulse |
| rfault_evt | input | 1 | Remote-fault detection pulse |
| an_done | input | 1 | Negotiation-complete indication |
| an_restart_ack | input | 1 | Datapath acknowledges a negotiation restart |
| lp_ability | input | 16 | Partner ability word from negotiation |
| int_evt | input | INT_W | Interrupt event pulses into register 17 |
| ctrl_q | output | 16 | Control register contents |
| adv_q | output | 16 | Advertisement register contents |
| vend_q | output | 16 | Vendor control register (19) contents |
| mode_q | output | 16 | Mode register (20) contents |
| irq_n | output | 1 | Active-low interrupt |

## Verification
On every MDC cycle, the assertions check the turnaround zero, that drive begins only two cycles after a matched read was decoded, and the length of a drive window. They also check the values that follow a soft reset, the self-clear of the restart bit and the release of the interrupt after a register 17 read. The bench scenarios are needed to show the preamble count after reset, the idle-bit rule under suppression, address filtering, the latch-low and latch-high behaviour of the status bits, and that isolation depends on the strap alone.

// File: rtl/phy_mgmt_pkg.sv
// Shared constants and types for the PHY management slave.
// Assumes 16-bit registers and 5-bit register and PHY addresses.
package phy_mgmt_pkg;
    localparam int unsigned DW = 16;
    localparam int unsigned AW = 5;

    // Register addresses
    localparam logic [4:0] RA_CTRL = 5'd0;
    localparam logic [4:0] RA_STAT = 5'd1;
    localparam logic [4:0] RA_ID1  = 5'd2;
    localparam logic [4:0] RA_ID2  = 5'd3;
    localparam logic [4:0] RA_ADV  = 5'd4;
    localparam logic [4:0] RA_LPA  = 5'd5;
    localparam logic [4:0] RA_EXP  = 5'd6;
    localparam logic [4:0] RA_ISR  = 5'd17;
    localparam logic [4:0] RA_IER  = 5'd18;
    localparam logic [4:0] RA_VEND = 5'd19;
    localparam logic [4:0] RA_MODE = 5'd20;

    // Writable-bit masks
    localparam logic [15:0] CTRL_WMASK = 16'h7F80;
    localparam logic [15:0] ADV_WMASK  = 16'h25FF;
    localparam logic [15:0] MODE_WMASK = 16'h08FA;

    // Serial engine phases
    typedef enum logic [1:0] {
        FS_IDLE,
        FS_HDR,
        FS_TA,
        FS_DATA
    } fs_t;
endpackage

// File: rtl/mgmt_frame_engine.sv
// Serial frame engine. Counts preamble ones, decodes start, opcode,
// PHY address and register address, then handles turnaround and data.
// Assumes mdio_in is already synchronous to clk (MDC). It issues a
// one-cycle read request on the last address bit and a one-cycle write
// request on the last data bit.
module mgmt_frame_engine
    import phy_mgmt_pkg::*;
#(
    parameter int unsigned PRE_LEN = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mdio_in,
    input  logic [AW-1:0] my_addr,
    input  logic          presupp_en,
    input  logic [DW-1:0] rd_data,
    output logic          rd_req,
    output logic          wr_req,
    output logic [AW-1:0] reg_addr,
    output logic [DW-1:0] wr_data,
    output logic          mdio_out,
    output logic          mdio_oe
);
    localparam int unsigned PRE_CW  = $clog2(PRE_LEN + 1);
    localparam int unsigned HDR_W   = 3 + 2 * AW;   // start bit 2, opcode, addresses
    localparam int unsigned CNT_W   = $clog2(DW);
    localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_W - 1);
    localparam logic [CNT_W-1:0] DAT_LAST = CNT_W'(DW - 1);
    localparam logic [PRE_CW-1:0] PRE_FULL = PRE_CW'(PRE_LEN);

    fs_t              state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [PRE_CW-1:0] pre_q;
    logic [HDR_W-1:0] hdr_q;
    logic [DW-1:0]    sh_q;
    logic [AW-1:0]    addr_q;
    logic             hit_q;
    logic             is_rd_q;
    logic             seen_q;

    logic [HDR_W-1:0] hdr_nx;
    logic             hdr_ok;
    logic             op_rd;
    logic             op_wr;
    logic             start_ok;

    // Header decode from the bits so far plus the bit on the line now
    assign hdr_nx   = {hdr_q[HDR_W-2:0], mdio_in};
    assign op_rd    = (hdr_nx[2*AW+1:2*AW] == 2'b10);
    assign op_wr    = (hdr_nx[2*AW+1:2*AW] == 2'b01);
    assign hdr_ok   = hdr_nx[HDR_W-1] && (hdr_nx[2*AW-1:AW] == my_addr);
    assign start_ok = (pre_q == PRE_FULL) || (presupp_en && seen_q && (pre_q != '0));

    // Register-file requests
    assign rd_req   = (state_q == FS_HDR) && (cnt_q == HDR_LAST) && hdr_ok && op_rd;
    assign wr_req   = (state_q == FS_DATA) && (cnt_q == DAT_LAST) && hit_q && !is_rd_q;
    assign reg_addr = (state_q == FS_HDR) ? hdr_nx[AW-1:0] : addr_q;
    assign wr_data  = {sh_q[DW-2:0], mdio_in};

    // Frame sequencing, shifting and line drive
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= FS_IDLE;
            cnt_q    <= '0;
            pre_q    <= '0;
            hdr_q    <= '0;
            sh_q     <= '0;
            addr_q   <= '0;
            hit_q    <= 1'b0;
            is_rd_q  <= 1'b0;
            seen_q   <= 1'b0;
            mdio_out <= 1'b0;
            mdio_oe  <= 1'b0;
        end else begin
            case (state_q)
                FS_IDLE: begin
                    mdio_oe <= 1'b0;
                    if (mdio_in) begin
                        if (pre_q != PRE_FULL) pre_q <= pre_q + 1'b1;
                    end else begin
                        pre_q <= '0;
                        if (start_ok) begin
                            state_q <= FS_HDR;
                            cnt_q   <= '0;
                        end
                    end
                end
                FS_HDR: begin
                    hdr_q <= hdr_nx;
                    if (cnt_q == HDR_LAST) begin
                        state_q <= FS_TA;
                        cnt_q   <= '0;
                        hit_q   <= hdr_ok && (op_rd || op_wr);
                        is_rd_q <= op_rd;
                        addr_q  <= hdr_nx[AW-1:0];
                        if (rd_req) sh_q <= rd_data;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                FS_TA: begin
                    if (cnt_q == '0) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (hit_q && is_rd_q) begin
                            mdio_oe  <= 1'b1;
                            mdio_out <= 1'b0;
                        end
                    end else begin
                        state_q <= FS_DATA;
                        cnt_q   <= '0;
                        if (hit_q && is_rd_q) begin
                            mdio_out <= sh_q[DW-1];
                            sh_q     <= {sh_q[DW-2:0], 1'b0};
                        end
                    end
                end
                FS_DATA: begin
                    if (hit_q && is_rd_q) begin
                        mdio_out <= sh_q[DW-1];
                        sh_q     <= {sh_q[DW-2:0], 1'b0};
                    end else begin
                        sh_q <= wr_data;
                    end
                    if (cnt_q == DAT_LAST) begin
                        state_q <= FS_IDLE;
                        mdio_oe <= 1'b0;
                        seen_q  <= 1'b1;
                        pre_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= FS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mgmt_reg_file.sv
// Management register file. Holds control, advertisement, interrupt
// enable, vendor and mode registers, and builds the status word from
// latched bits. Read side effects (latch reload, interrupt clear) take
// place in the cycle of rd_req. Assumes INT_W < 16.
module mgmt_reg_file
    import phy_mgmt_pkg::*;
#(
    parameter int unsigned INT_W    = 8,
    parameter logic [15:0] ID1      = 16'h1C04,
    parameter logic [15:0] ID2      = 16'h5C31,
    parameter logic [15:0] ADV_DEF  = 16'h01E1,
    parameter logic [15:0] VEND_DEF = 16'h00C0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    strap_addr,
    input  logic             rd_req,
    input  logic             wr_req,
    input  logic [AW-1:0]    reg_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic             link_up,
    input  logic             jabber_evt,
    input  logic             rfault_evt,
    input  logic             an_done,
    input  logic             an_restart_ack,
    input  logic [DW-1:0]    lp_ability,
    input  logic [INT_W-1:0] int_evt,
    output logic [DW-1:0]    rd_data,
    output logic [DW-1:0]    ctrl_q,
    output logic [DW-1:0]    adv_q,
    output logic [DW-1:0]    vend_q,
    output logic [DW-1:0]    mode_q,
    output logic [AW-1:0]    my_addr,
    output logic             presupp_en,
    output logic             irq_n
);
    localparam int unsigned PAD_W = DW - INT_W;

    logic [DW-1:0]    ctrl_r, adv_r, vend_r, mode_r;
    logic [INT_W-1:0] isr_r, ier_r;
    logic [AW-1:0]    addr_r;
    logic             link_ll, jab_lh, rf_lh;
    logic             soft_rst, rd_stat, rd_isr;
    logic [DW-1:0]    stat_w;

    assign soft_rst = wr_req && (reg_addr == RA_CTRL) && wr_data[15];
    assign rd_stat  = rd_req && (reg_addr == RA_STAT);
    assign rd_isr   = rd_req && (reg_addr == RA_ISR);

    // Writable registers with hardware and soft reset defaults
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            ctrl_r <= {4'b0011, 1'b0, (strap_addr == '0), 10'b0};
            adv_r  <= ADV_DEF;
            vend_r <= VEND_DEF;
            ier_r  <= '0;
            mode_r <= {8'h00, strap_addr, 3'b010};
            addr_r <= strap_addr;
        end else begin
            if (wr_req && reg_addr == RA_CTRL) ctrl_r <= wr_data & CTRL_WMASK;
            else if (an_restart_ack)           ctrl_r[9] <= 1'b0;
            if (wr_req && reg_addr == RA_ADV)  adv_r  <= wr_data & ADV_WMASK;
            if (wr_req && reg_addr == RA_VEND) vend_r <= wr_data;
            if (wr_req && reg_addr == RA_IER)  ier_r  <= wr_data[INT_W-1:0];
            if (wr_req && reg_addr == RA_MODE) mode_r <= wr_data & MODE_WMASK;
        end
    end

    // Latching status bits and interrupt status, reloaded on read
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            link_ll <= 1'b0;
            jab_lh  <= 1'b0;
            rf_lh   <= 1'b0;
            isr_r   <= '0;
        end else begin
            link_ll <= rd_stat ? link_up    : (link_ll & link_up);
            jab_lh  <= rd_stat ? jabber_evt : (jab_lh | jabber_evt);
            rf_lh   <= rd_stat ? rfault_evt : (rf_lh | rfault_evt);
            isr_r   <= rd_isr  ? int_evt    : (isr_r | int_evt);
        end
    end

    assign stat_w = {1'b0, 4'b1111, 4'b0000, mode_r[1], an_done, rf_lh,
                     1'b1, link_ll, jab_lh, 1'b1};

    // Read multiplexer
    always_comb begin
        case (reg_addr)
            RA_CTRL: rd_data = ctrl_r;
            RA_STAT: rd_data = stat_w;
            RA_ID1:  rd_data = ID1;
            RA_ID2:  rd_data = ID2;
            RA_ADV:  rd_data = adv_r;
            RA_LPA:  rd_data = lp_ability;
            RA_EXP:  rd_data = '0;
            RA_ISR:  rd_data = {{PAD_W{1'b0}}, isr_r};
            RA_IER:  rd_data = {{PAD_W{1'b0}}, ier_r};
            RA_VEND: rd_data = vend_r;
            RA_MODE: rd_data = mode_r;
            default: rd_data = '0;
        endcase
    end

    assign ctrl_q     = ctrl_r;
    assign adv_q      = adv_r;
    assign vend_q     = vend_r;
    assign mode_q     = mode_r;
    assign my_addr    = addr_r;
    assign presupp_en = mode_r[1];
    assign irq_n      = ~|(isr_r & ier_r);
endmodule

// File: rtl/phy_mgmt_slave.sv
// Top of the PHY management slave: serial frame engine plus register
// file, both clocked by MDC. Assumes the line is resolved outside
// (mdio_in is the line level, mdio_oe/mdio_out drive it).
module phy_mgmt_slave
    import phy_mgmt_pkg::*;
#(
    parameter int unsigned PRE_LEN  = 32,
    parameter int unsigned INT_W    = 8,
    parameter logic [15:0] ID1      = 16'h1C04,
    parameter logic [15:0] ID2      = 16'h5C31,
    parameter logic [15:0] ADV_DEF  = 16'h01E1,
    parameter logic [15:0] VEND_DEF = 16'h00C0
) (
    input  logic             mdc,
    input  logic             rst_n,
    input  logic             mdio_in,
    output logic             mdio_out,
    output logic             mdio_oe,
    input  logic [4:0]       strap_addr,
    input  logic             link_up,
    input  logic             jabber_evt,
    input  logic             rfault_evt,
    input  logic             an_done,
    input  logic             an_restart_ack,
    input  logic [15:0]      lp_ability,
    input  logic [INT_W-1:0] int_evt,
    output logic [15:0]      ctrl_q,
    output logic [15:0]      adv_q,
    output logic [15:0]      vend_q,
    output logic [15:0]      mode_q,
    output logic             irq_n
);
    logic          rd_req, wr_req, presupp_en;
    logic [AW-1:0] reg_addr, my_addr;
    logic [DW-1:0] wr_data, rd_data;

    mgmt_frame_engine #(.PRE_LEN(PRE_LEN)) u_eng (
        .clk        (mdc),
        .rst_n      (rst_n),
        .mdio_in    (mdio_in),
        .my_addr    (my_addr),
        .presupp_en (presupp_en),
        .rd_data    (rd_data),
        .rd_req     (rd_req),
        .wr_req     (wr_req),
        .reg_addr   (reg_addr),
        .wr_data    (wr_data),
        .mdio_out   (mdio_out),
        .mdio_oe    (mdio_oe)
    );

    mgmt_reg_file #(
        .INT_W(INT_W), .ID1(ID1), .ID2(ID2), .ADV_DEF(ADV_DEF), .VEND_DEF(VEND_DEF)
    ) u_regs (
        .clk            (mdc),
        .rst_n          (rst_n),
        .strap_addr     (strap_addr),
        .rd_req         (rd_req),
        .wr_req         (wr_req),
        .reg_addr       (reg_addr),
        .wr_data        (wr_data),
        .link_up        (link_up),
        .jabber_evt     (jabber_evt),
        .rfault_evt     (rfault_evt),
        .an_done        (an_done),
        .an_restart_ack (an_restart_ack),
        .lp_ability     (lp_ability),
        .int_evt        (int_evt),
        .rd_data        (rd_data),
        .ctrl_q         (ctrl_q),
        .adv_q          (adv_q),
        .vend_q         (vend_q),
        .mode_q         (mode_q),
        .my_addr        (my_addr),
        .presupp_en     (presupp_en),
        .irq_n          (irq_n)
    );
endmodule

// File: rtl/phy_mgmt_slave_chk.sv
// Protocol and register checker for phy_mgmt_slave, bound to the top.
// Watches the line drive window, soft reset, restart self-clear and
// interrupt release after a status read.
module phy_mgmt_slave_chk #(
    parameter int unsigned INT_W = 8
) (
    input logic             mdc,
    input logic             rst_n,
    input logic             mdio_out,
    input logic             mdio_oe,
    input logic             rd_req,
    input logic             wr_req,
    input logic [4:0]       reg_addr,
    input logic [15:0]      wr_data,
    input logic [15:0]      ctrl_q,
    input logic             an_restart_ack,
    input logic [INT_W-1:0] int_evt,
    input logic             irq_n
);
    logic [5:0] oe_run;

    // Length of the current drive window
    always_ff @(posedge mdc) begin
        if (!rst_n)       oe_run <= '0;
        else if (mdio_oe) oe_run <= oe_run + 1'b1;
        else              oe_run <= '0;
    end

    AST_TA_ZERO: assert property (@(posedge mdc) disable iff (!rst_n)
        $rose(mdio_oe) |-> !mdio_out);                                  // R5
    AST_OE_WINDOW: assert property (@(posedge mdc) disable iff (!rst_n)
        oe_run <= 6'd17);                                               // R5
    AST_OE_AFTER_READ: assert property (@(posedge mdc) disable iff (!rst_n)
        $rose(mdio_oe) |-> $past(rd_req, 2));                           // R4
    AST_SOFT_RESET: assert property (@(posedge mdc) disable iff (!rst_n)
        (wr_req && reg_addr == 5'd0 && wr_data[15]) |=> (ctrl_q[15:11] == 5'b00110) && !ctrl_q[9]); // R7
    AST_AN_SELF_CLEAR: assert property (@(posedge mdc) disable iff (!rst_n)
        (ctrl_q[9] && an_restart_ack && !wr_req) |=> !ctrl_q[9]);       // R8
    AST_IRQ_RELEASE: assert property (@(posedge mdc) disable iff (!rst_n)
        (rd_req && reg_addr == 5'd17 && int_evt == '0) |=> irq_n);      // R10
endmodule

bind phy_mgmt_slave phy_mgmt_slave_chk #(.INT_W(INT_W)) u_chk (
    .mdc            (mdc),
    .rst_n          (rst_n),
    .mdio_out       (mdio_out),
    .mdio_oe        (mdio_oe),
    .rd_req         (rd_req),
    .wr_req         (wr_req),
    .reg_addr       (reg_addr),
    .wr_data        (wr_data),
    .ctrl_q         (ctrl_q),
    .an_restart_ack (an_restart_ack),
    .int_evt        (int_evt),
    .irq_n          (irq_n)
);

// File: tb/phy_mgmt_slave_bench.sv
// Directed bench for phy_mgmt_slave: one task per scenario.
module phy_mgmt_slave_bench;
    logic        mdc = 1'b0;
    logic        rst_n = 1'b0;
    logic        mst = 1'b0;
    logic        mdio_out, mdio_oe, irq_n;
    logic [4:0]  strap_addr = 5'd5;
    logic        link_up = 1'b1, jabber_evt = 1'b0, rfault_evt = 1'b0;
    logic        an_done = 1'b0, an_restart_ack = 1'b0;
    logic [15:0] lp_ability = 16'h45E1;
    logic [7:0]  int_evt = 8'h00;
    logic [15:0] ctrl_q, adv_q, vend_q, mode_q;
    logic        mdio_in;
    int          checks = 0, fails = 0;
    logic        ta1_oe, end_oe;
    bit          done = 0;

    always #4 mdc = ~mdc;
    assign mdio_in = mdio_oe ? mdio_out : mst;

    phy_mgmt_slave u_phy_mgmt_slave (
        .mdc(mdc), .rst_n(rst_n), .mdio_in(mdio_in), .mdio_out(mdio_out),
        .mdio_oe(mdio_oe), .strap_addr(strap_addr), .link_up(link_up),
        .jabber_evt(jabber_evt), .rfault_evt(rfault_evt), .an_done(an_done),
        .an_restart_ack(an_restart_ack), .lp_ability(lp_ability),
        .int_evt(int_evt), .ctrl_q(ctrl_q), .adv_q(adv_q), .vend_q(vend_q),
        .mode_q(mode_q), .irq_n(irq_n)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic hw_reset(input logic [4:0] s);
        rst_n = 1'b0; mst = 1'b0; strap_addr = s;
        repeat (3) @(negedge mdc);
        rst_n = 1'b1;
    endtask

    task automatic xfer(input int pre, input bit rd, input logic [4:0] phy,
                        input logic [4:0] ra, input logic [15:0] wd,
                        output logic [15:0] rv, output bit resp);
        logic [13:0] hdr;
        bit ok;
        hdr = {2'b01, (rd ? 2'b10 : 2'b01), phy, ra};
        rv = '0; resp = 0;
        repeat (pre) @(negedge mdc) mst = 1'b1;
        for (int i = 13; i >= 0; i--) begin
            @(negedge mdc) mst = hdr[i];
        end
        if (rd) begin
            @(negedge mdc) mst = 1'b1;
            ta1_oe = mdio_oe;
            @(negedge mdc);
            ok = mdio_oe && !mdio_out;
            for (int i = 0; i < 16; i++) begin
                @(negedge mdc);
                ok = ok && mdio_oe;
                rv = {rv[14:0], mdio_out};
            end
            @(negedge mdc);
            end_oe = mdio_oe;
            resp = ok && !ta1_oe;
            if (!resp) rv = '0;
        end else begin
            @(negedge mdc) mst = 1'b1;
            @(negedge mdc) mst = 1'b0;
            for (int i = 15; i >= 0; i--) begin
                @(negedge mdc) mst = wd[i];
            end
            @(negedge mdc) mst = 1'b1;
        end
    endtask

    task automatic rd_reg(input string tag, input int pre, input logic [4:0] ra,
                          input logic [15:0] exp);
        logic [15:0] v; bit r;
        xfer(pre, 1, strap_addr, ra, 16'h0, v, r);
        chk({tag, " answered"}, {15'b0, r}, 16'h0001);
        chk(tag, v, exp);
    endtask

    task automatic wr_reg(input int pre, input logic [4:0] ra, input logic [15:0] wd);
        logic [15:0] v; bit r;
        xfer(pre, 0, strap_addr, ra, wd, v, r);
    endtask

    task automatic t_reset_ports;  // R1
        chk("R1 oe after reset", {15'b0, mdio_oe}, 16'h0000);
        chk("R1 irq_n after reset", {15'b0, irq_n}, 16'h0001);
        chk("R1 ctrl_q", ctrl_q, 16'h3000);
        chk("R1 mode_q", mode_q, 16'h002A);
    endtask

    task automatic t_preamble;  // R2
        logic [15:0] v; bit r;
        xfer(31, 1, 5'd5, 5'd2, 16'h0, v, r);
        chk("R2 31 ones ignored", {15'b0, r}, 16'h0000);
        rd_reg("R2 32 ones", 32, 5'd2, 16'h1C04);
    endtask

    task automatic t_defaults;  // R1
        rd_reg("R1 reg0", 0, 5'd0, 16'h3000);
        rd_reg("R1 reg4", 0, 5'd4, 16'h01E1);
        rd_reg("R1 reg5", 0, 5'd5, 16'h45E1);
        rd_reg("R1 reg20", 0, 5'd20, 16'h002A);
    endtask

    task automatic t_turnaround;  // R5
        rd_reg("R5 reg3 data", 0, 5'd3, 16'h5C31);
        chk("R5 first TA released", {15'b0, ta1_oe}, 16'h0000);
        chk("R5 released after data", {15'b0, end_oe}, 16'h0000);
    endtask

    task automatic t_suppress;  // R3
        logic [15:0] v; bit r;
        xfer(0, 1, 5'd5, 5'd1, 16'h0, v, r);
        chk("R3 answered with one idle", {15'b0, r}, 16'h0001);
        chk("R3 reg1 bit6 set", {15'b0, v[6]}, 16'h0001);
        wr_reg(0, 5'd20, 16'h0028);
        xfer(0, 1, 5'd5, 5'd2, 16'h0, v, r);
        chk("R3 ignored when disabled", {15'b0, r}, 16'h0000);
        xfer(32, 1, 5'd5, 5'd1, 16'h0, v, r);
        chk("R3 reg1 bit6 clear", {15'b0, v[6]}, 16'h0000);
        wr_reg(32, 5'd20, 16'h002A);
    endtask

    task automatic t_addr;  // R4
        logic [15:0] v; bit r;
        xfer(0, 1, 5'd6, 5'd2, 16'h0, v, r);
        chk("R4 other address not answered", {15'b0, r}, 16'h0000);
        xfer(0, 0, 5'd6, 5'd19, 16'hBEEF, v, r);
        rd_reg("R4 write to other address ignored", 0, 5'd19, 16'h00C0);
    endtask

    task automatic t_latch;  // R9
        logic [15:0] v; bit r;
        xfer(0, 1, 5'd5, 5'd1, 16'h0, v, r);
        rd_reg("R9 steady link", 0, 5'd1, 16'h784D);
        @(negedge mdc) link_up = 1'b0;
        @(negedge mdc) link_up = 1'b1;
        rd_reg("R9 link latched low", 0, 5'd1, 16'h7849);
        rd_reg("R9 link reloaded", 0, 5'd1, 16'h784D);
        @(negedge mdc) jabber_evt = 1'b1;
        @(negedge mdc) jabber_evt = 1'b0;
        rd_reg("R9 jabber latched", 0, 5'd1, 16'h784F);
        rd_reg("R9 jabber cleared", 0, 5'd1, 16'h784D);
        @(negedge mdc) rfault_evt = 1'b1;
        @(negedge mdc) rfault_evt = 1'b0;
        rd_reg("R9 remote fault latched", 0, 5'd1, 16'h785D);
        rd_reg("R9 remote fault cleared", 0, 5'd1, 16'h784D);
    endtask

    task automatic t_irq;  // R10
        wr_reg(0, 5'd18, 16'h0001);
        @(negedge mdc) int_evt = 8'h02;
        @(negedge mdc) int_evt = 8'h00;
        chk("R10 masked event no irq", {15'b0, irq_n}, 16'h0001);
        rd_reg("R10 isr masked bit", 0, 5'd17, 16'h0002);
        @(negedge mdc) int_evt = 8'h01;
        @(negedge mdc) int_evt = 8'h00;
        chk("R10 enabled event irq low", {15'b0, irq_n}, 16'h0000);
        rd_reg("R10 isr enabled bit", 0, 5'd17, 16'h0001);
        chk("R10 irq released by read", {15'b0, irq_n}, 16'h0001);
        rd_reg("R10 isr cleared", 0, 5'd17, 16'h0000);
    endtask

    task automatic t_unimpl;  // R11
        rd_reg("R11 reg7 reads 0", 0, 5'd7, 16'h0000);
        wr_reg(0, 5'd21, 16'hFFFF);
        rd_reg("R11 reg21 write ignored", 0, 5'd21, 16'h0000);
        wr_reg(0, 5'd2, 16'h0000);
        rd_reg("R11 id1 read only", 0, 5'd2, 16'h1C04);
    endtask

    task automatic t_an_restart;  // R8
        wr_reg(0, 5'd0, 16'h3200);
        rd_reg("R8 restart held", 0, 5'd0, 16'h3200);
        @(negedge mdc) an_restart_ack = 1'b1;
        @(negedge mdc) an_restart_ack = 1'b0;
        rd_reg("R8 restart cleared", 0, 5'd0, 16'h3000);
    endtask

    task automatic t_soft_reset;  // R7
        wr_reg(0, 5'd0, 16'h4100);
        rd_reg("R7 ctrl written", 0, 5'd0, 16'h4100);
        wr_reg(0, 5'd19, 16'h1234);
        wr_reg(0, 5'd20, 16'h0020);
        wr_reg(32, 5'd0, 16'h8000);
        chk("R7 ctrl_q default", ctrl_q, 16'h3000);
        rd_reg("R7 reg0 default", 32, 5'd0, 16'h3000);
        rd_reg("R7 reg19 default", 0, 5'd19, 16'h00C0);
        rd_reg("R7 reg20 default", 0, 5'd20, 16'h002A);
    endtask

    task automatic t_isolate;  // R6
        wr_reg(0, 5'd20, 16'h0002);
        rd_reg("R6 no isolate after write", 0, 5'd0, 16'h3000);
        hw_reset(5'd0);
        chk("R6 ctrl_q isolate", ctrl_q, 16'h3400);
        rd_reg("R6 reg0 isolate from strap", 32, 5'd0, 16'h3400);
    endtask

    initial begin
        hw_reset(5'd5);
        t_reset_ports();
        t_preamble();
        t_defaults();
        t_turnaround();
        t_suppress();
        t_addr();
        t_latch();
        t_irq();
        t_unimpl();
        t_an_restart();
        t_soft_reset();
        t_isolate();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge mdc);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule